// File: doc/BRIEF.md
# IrDA SIR Transmit Pulse Encoder

This block turns the NRZ serial output of a UART-style transmitter into the short optical pulses used by serial infrared links. A logic-zero bit cell produces one pulse at the start of the cell. A logic-one bit cell, which includes the idle line, produces no pulse. Two single-cycle enables pace the block. The first is a 16x oversampling tick for the bit rate in use. The second is a 16x tick fixed at 115,200 bit/s.

A mode input picks how wide a pulse is. In scaled mode the pulse lasts three periods of the bit-rate tick, which is 3/16 of a bit. In low-power mode the pulse always lasts three periods of the 115,200 bit/s tick, about 1.6 µs, at every bit rate. Low-power mode uses less transmit power but gives a shorter link range.

Bit cells are found by counting bit-rate ticks modulo the oversampling factor. The transmitter feeding the block must change its data in step with that count. The bit-rate tick must never come more often than the fixed-rate tick.

Top module: `irda_sir_tx`

## Requirements
- R1: While reset (rst_n = 0) is asserted, ir_out is low. It stays low after reset until the first zero bit cell starts.
- R2: A cell start is a rate_tick16 edge at which the cell phase is 0. The cell phase counts rate_tick16 pulses modulo 16, and the first tick after reset has phase 0. If tx_nrz = 0 at a cell start, ir_out goes high in the cycle right after that edge and produces exactly one pulse.
- R3: If tx_nrz = 1 at a cell start (a one bit or an idle line), no pulse occurs in that cell.
- R4: With low_power = 0 (scaled mode) sampled at the cell start, ir_out falls right after the third rate_tick16 edge that follows the start edge.
- R5: With low_power = 1 (fixed mode) sampled at the cell start, ir_out falls right after the third ref_tick16 edge that follows the start edge. The pulse always ends before the next cell start.
- R6: In fixed mode the pulse width depends only on ref_tick16. It is the same at every bit rate whose tick period is a whole multiple of the reference tick period.
- R7: low_power is sampled only at a cell start. A change while a pulse is in progress does not alter that pulse. The new value applies from the next zero bit.
- R8: tx_nrz is sampled only at a cell start. A drop to 0 partway through a one cell produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_tick16 | input | 1 | Single-cycle enable at 16x the selected bit rate |
| ref_tick16 | input | 1 | Single-cycle enable at 16x 115,200 bit/s |
| tx_nrz | input | 1 | NRZ transmit data; 0 = zero bit, 1 = one bit or idle |
| low_power | input | 1 | Width mode: 0 = scaled, 1 = fixed 115,200 bit/s width |
| ir_out | output | 1 | Optical pulse drive, active high |

## Verification
A phase counter that is out of step shows at ir_out as a pulse starting on a cycle other than the edge right after a 16th-tick cell start. It also shows as a pulse appearing in a one cell, and either fault appears within one bit cell. A wrong width counter or a stale mode latch moves the falling edge of ir_out by one or more tick periods. That error shows on the first zero bit after the fault. The bench therefore records the cycle of every rising and falling edge against a scoreboard of start and stop cycles. Those cycles are computed from the tick schedule and the mode in force at each cell start.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
   typedef enum logic {
      WIDTH_SCALED = 1'b0,
      WIDTH_FIXED  = 1'b1
   } width_mode_e;
endpackage

// File: rtl/irtx_cell_phase.sv
module irtx_cell_phase #(
   parameter int PHASES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_tick,
   output logic cell_start
);
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
   localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

   logic [PW-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (rate_tick) begin
         phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
   end

   assign cell_start = rate_tick && (phase == '0);
endmodule

// File: rtl/irtx_pulse_timer.sv
module irtx_pulse_timer #(
   parameter int PULSE_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic tick,
   output logic pulse
);
   generate
      if (PULSE_TICKS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)          pulse <= 1'b0;
            else if (fire)       pulse <= 1'b1;
            else if (tick)       pulse <= 1'b0;
         end
      end else begin : g_count
         localparam int CW = $clog2(PULSE_TICKS);
         localparam logic [CW-1:0] END_CNT = CW'(PULSE_TICKS - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pulse <= 1'b0;
               cnt   <= '0;
            end else if (fire) begin
               pulse <= 1'b1;
               cnt   <= '0;
            end else if (pulse && tick) begin
               if (cnt == END_CNT) begin
                  pulse <= 1'b0;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irda_sir_tx.sv
module irda_sir_tx
   import irtx_pkg::*;
#(
   parameter int PHASES      = 16,
   parameter int PULSE_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_tick16,
   input  logic ref_tick16,
   input  logic tx_nrz,
   input  logic low_power,
   output logic ir_out
);
   generate
      if (PHASES < 4) begin : g_bad_phases
         $error("irda_sir_tx: PHASES must be at least 4");
      end
      if (PULSE_TICKS < 1 || PULSE_TICKS >= PHASES) begin : g_bad_ticks
         $error("irda_sir_tx: PULSE_TICKS must lie in 1..PHASES-1");
      end
   endgenerate

   logic        cell_start;
   logic        fire;
   logic        tick_sel;
   width_mode_e mode_q;

   irtx_cell_phase #(.PHASES(PHASES)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_tick  (rate_tick16),
      .cell_start (cell_start)
   );

   assign fire = cell_start && !tx_nrz;

   // width mode is captured once per zero bit and held for the pulse
   always_ff @(posedge clk) begin
      if (!rst_n)    mode_q <= WIDTH_SCALED;
      else if (fire) mode_q <= width_mode_e'(low_power);
   end

   assign tick_sel = (mode_q == WIDTH_FIXED) ? ref_tick16 : rate_tick16;

   irtx_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .tick  (tick_sel),
      .pulse (ir_out)
   );
endmodule

// File: rtl/irda_sir_tx_chk.sv
module irda_sir_tx_chk
   import irtx_pkg::*;
#(
   parameter int PULSE_TICKS = 3
) (
   input logic        clk,
   input logic        rst_n,
   input logic        rate_tick16,
   input logic        ref_tick16,
   input logic        tx_nrz,
   input logic        low_power,
   input logic        ir_out,
   input logic        cell_start,
   input width_mode_e mode_q
);
   logic [7:0] seen;
   logic       own_tick;

   assign own_tick = (mode_q == WIDTH_FIXED) ? ref_tick16 : rate_tick16;

   always_ff @(posedge clk) begin
      if (!rst_n)                       seen <= '0;
      else if (cell_start && !tx_nrz)   seen <= '0;
      else if (ir_out && own_tick)      seen <= seen + 1'b1;
   end

   a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !ir_out);

   a_r2_zero_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_start && !tx_nrz) |=> ir_out);

   a_r3_no_stray_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ir_out) |-> $past(cell_start && !tx_nrz));

   a_r4_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ir_out |-> (seen < 8'(PULSE_TICKS)));

   a_r4_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_out && !own_tick && !(cell_start && !tx_nrz)) |=> ir_out);

   a_r5_fits_cell: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start |-> !ir_out);

   a_r7_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_start && !tx_nrz) |=> (mode_q == width_mode_e'($past(low_power))));

   a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_out && !(cell_start && !tx_nrz)) |=> $stable(mode_q));
endmodule

bind irda_sir_tx irda_sir_tx_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rate_tick16 (rate_tick16),
   .ref_tick16  (ref_tick16),
   .tx_nrz      (tx_nrz),
   .low_power   (low_power),
   .ir_out      (ir_out),
   .cell_start  (cell_start),
   .mode_q      (mode_q)
);

// File: tb/tb_irda_sir_tx.sv
`timescale 1ns/1ps
module tb_irda_sir_tx;
   localparam int REF_DIV = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rate_tick16 = 1'b0;
   logic ref_tick16 = 1'b0;
   logic tx_nrz = 1'b1;
   logic low_power = 1'b0;
   logic ir_out;

   int edge_no = 0;
   int tick_idx = 0;
   int rd = 8;
   int checks = 0;
   int errors = 0;
   int rises = 0;
   bit ended = 0;
   logic ir_prev = 1'b0;

   typedef struct {
      int start;
      int stop;
      int req;
   } exp_t;
   exp_t q[$];

   irda_sir_tx dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rate_tick16 (rate_tick16),
      .ref_tick16  (ref_tick16),
      .tx_nrz      (tx_nrz),
      .low_power   (low_power),
      .ir_out      (ir_out)
   );

   always #2 clk = ~clk;

   // tick generator: tick on posedge number n when n is a multiple of the divider
   always @(posedge clk) begin
      edge_no = edge_no + 1;
      if (rst_n && rate_tick16) tick_idx = tick_idx + 1;
      #1;
      rate_tick16 = ((edge_no + 1) % rd == 0);
      ref_tick16  = ((edge_no + 1) % REF_DIV == 0);
   end

   function automatic int third_after(int p, int d);
      return ((p / d) + 1) * d + 2 * d;
   endfunction

   task automatic wait_cell();
      do @(negedge clk); while (!(rst_n && rate_tick16 && (tick_idx % 16 == 0)));
   endtask

   // driver: presents one bit at the next cell start and queues the expected pulse
   task automatic send_bit(input logic b, input logic lp, input int new_rd,
                           input int flip_after, input logic flip_lp, input logic flip_tx);
      int p;
      int r0;
      int d;
      wait_cell();
      r0 = rises;
      tx_nrz    = b;
      low_power = lp;
      rd        = new_rd;
      p = edge_no + 1;
      if (!b) begin
         d = lp ? REF_DIV : new_rd;
         q.push_back('{start: p, stop: third_after(p, d), req: lp ? 5 : 4});
      end
      if (flip_after > 0) begin
         repeat (flip_after) @(negedge clk);
         if (flip_lp) low_power = ~lp;
         if (flip_tx) tx_nrz = 1'b0;
      end
      if (b) begin
         // R3 / R8: one cell, checked at the ports through the rise count
         repeat (16 * new_rd - flip_after - 2) @(negedge clk);
         checks++;
         if (rises != r0) begin
            errors++;
            $display("FAIL R3/R8: %0d pulses in a one cell, expected 0", rises - r0);
         end
      end
   endtask

   // monitor: compares every edge of ir_out with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ir_out && !ir_prev) begin
            rises++;
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R3: pulse rose at edge %0d, expected no pulse", edge_no);
            end else if (edge_no != q[0].start) begin
               errors++;
               $display("FAIL R2: pulse rose at edge %0d, expected %0d", edge_no, q[0].start);
            end
         end
         if (!ir_out && ir_prev && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (edge_no != e.stop) begin
               errors++;
               $display("FAIL R%0d: pulse fell at edge %0d, expected %0d (width %0d vs %0d)",
                        e.req, edge_no, e.stop, edge_no - e.start, e.stop - e.start);
            end
         end
      end
      ir_prev = ir_out;
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      checks++;   // R1 during reset
      if (ir_out !== 1'b0) begin
         errors++;
         $display("FAIL R1: ir_out=%b in reset, expected 0", ir_out);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      checks++;   // R1 after reset release
      if (ir_out !== 1'b0) begin
         errors++;
         $display("FAIL R1: ir_out=%b after reset, expected 0", ir_out);
      end

      send_bit(1'b1, 1'b0, 8, 0, 1'b0, 1'b0);   // R3 idle line
      send_bit(1'b0, 1'b0, 8, 0, 1'b0, 1'b0);   // R2 R4
      send_bit(1'b0, 1'b0, 8, 0, 1'b0, 1'b0);   // R2 back-to-back zeros
      send_bit(1'b1, 1'b0, 8, 0, 1'b0, 1'b0);   // R3
      send_bit(1'b0, 1'b0, 16, 0, 1'b0, 1'b0);  // R4 slower rate
      send_bit(1'b0, 1'b0, 12, 0, 1'b0, 1'b0);  // R4
      send_bit(1'b0, 1'b1, 8, 0, 1'b0, 1'b0);   // R5 R6
      send_bit(1'b0, 1'b1, 16, 0, 1'b0, 1'b0);  // R6 same width at another rate
      send_bit(1'b0, 1'b1, 24, 0, 1'b0, 1'b0);  // R6
      send_bit(1'b0, 1'b1, 12, 0, 1'b0, 1'b0);  // R5 unaligned ticks
      send_bit(1'b0, 1'b0, 16, 2, 1'b1, 1'b0);  // R7 switch to fixed mid-pulse
      send_bit(1'b0, 1'b1, 16, 0, 1'b0, 1'b0);  // R7 new mode applies
      send_bit(1'b0, 1'b1, 16, 3, 1'b1, 1'b0);  // R7 switch to scaled mid-pulse
      send_bit(1'b0, 1'b0, 16, 0, 1'b0, 1'b0);  // R7
      send_bit(1'b1, 1'b0, 16, 5, 1'b0, 1'b1);  // R8 data drop inside a one cell
      send_bit(1'b1, 1'b0, 8, 0, 1'b0, 1'b0);   // R3
      wait_cell();
      checks++;   // R2: every queued pulse appeared
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R2: %0d expected pulses missing, expected 0", q.size());
      end
      finish_run();
   end
endmodule